// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the scan timing for a video output. A pixel counter steps once per clock and a line counter steps each time the pixel counter wraps. Every limit is a live input: the line length, the frame length, the horizontal and vertical display windows, the sync pulse widths and polarities, interlace, and three interrupt positions. The block is meant to sit behind a register file owned by the surrounding chip, which holds these values steady while a mode runs.

From the two counters the block derives horizontal and vertical sync, horizontal and vertical blanking, a combined border flag (which a blank-screen control can force over the whole picture), the current line and the current field. It raises three kinds of one-clock interrupt: two independent line-match interrupts, and a pixel-position interrupt that can fire on one chosen line or on every line.

Top module: `raster_timing_gen`

## Requirements
- R1: The pixel counter counts 0, 1, ... up to `h_last_i` and then returns to 0 on the next clock.
- R2: `line_o` holds the line counter. It advances by one on each clock where the pixel counter wraps, and after line `v_last_i` it returns to 0.
- R3: `hblank_o` is 1 when the pixel count lies outside the half-open window [`h_win_start_i`, `h_win_end_i`). `vblank_o` is 1 when the line lies outside [`v_win_start_i`, `v_win_end_i`).
- R4: The hsync pulse is active for pixel counts below `hsync_width_i`, and the vsync pulse is active for lines below `vsync_width_i`. An active pulse drives the level of its polarity input (1 gives a positive pulse, 0 a negative one), and an inactive pulse drives the inverse level.
- R5: `border_o` is 1 when `hblank_o` or `vblank_o` is 1, and is 1 on every pixel while `full_border_i` is 1.
- R6: `irq_line_a_o` is 1 at pixel 0 of line `irq_line_a_pos_i`, and `irq_line_b_o` is 1 at pixel 0 of line `irq_line_b_pos_i`. The two are independent.
- R7: `irq_hpos_o` is 1 at pixel `irq_hpos_pix_i`. The condition on the line depends on `irq_hpos_mode_i`: mode 0 requires the line to equal `irq_hpos_line_i`, mode 2 accepts every line, and modes 1 and 3 never fire.
- R8: `field_o` changes only on the clock where both counters wrap. At that clock it toggles when `interlace_i` is 1 and becomes 0 when `interlace_i` is 0. The value 0 means the odd field and 1 means the even field.
- R9: While `h_last_i` is not 0, each interrupt is high for exactly one clock at a time.
- R10: While `rst_n` is low, both counters and `field_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| h_last_i | input | 10 | Last pixel count of a line |
| v_last_i | input | 10 | Last line of a frame |
| h_win_start_i | input | 10 | First pixel inside the horizontal window |
| h_win_end_i | input | 10 | First pixel past the horizontal window |
| v_win_start_i | input | 10 | First line inside the vertical window |
| v_win_end_i | input | 10 | First line past the vertical window |
| hsync_width_i | input | 7 | Hsync pulse length in pixels |
| vsync_width_i | input | 4 | Vsync pulse length in lines |
| hsync_pol_i | input | 1 | Hsync active level |
| vsync_pol_i | input | 1 | Vsync active level |
| interlace_i | input | 1 | Field toggling enable |
| full_border_i | input | 1 | Force the border over the whole screen |
| irq_line_a_pos_i | input | 10 | Line for interrupt A |
| irq_line_b_pos_i | input | 10 | Line for interrupt B |
| irq_hpos_pix_i | input | 10 | Pixel for the position interrupt |
| irq_hpos_line_i | input | 10 | Line for the position interrupt in mode 0 |
| irq_hpos_mode_i | input | 2 | Position interrupt mode |
| hsync_o | output | 1 | Horizontal sync level |
| vsync_o | output | 1 | Vertical sync level |
| hblank_o | output | 1 | Horizontal blanking status |
| vblank_o | output | 1 | Vertical blanking status |
| border_o | output | 1 | Border colour select |
| field_o | output | 1 | Current field |
| line_o | output | 10 | Current line |
| irq_line_a_o | output | 1 | Line interrupt A pulse |
| irq_line_b_o | output | 1 | Line interrupt B pulse |
| irq_hpos_o | output | 1 | Position interrupt pulse |

## Verification
A short line and a short frame are compared against counts derived from the clock number since reset, over several whole frames. Walking the counter wraps shows that line and frame rollover occur at the programmed last values and not one step off. Each sync polarity is run, which separates the pulse width from the pulse level, and the full-border control is run against ordinary windowing. All four position-interrupt modes are run with pulses counted per frame, which distinguishes one-line, every-line and silent behaviour. An interlaced run is compared with a progressive run, which separates field toggling from field clearing.

// File: rtl/raster_pkg.sv
package raster_pkg;
    localparam int RT_CNT_W  = 10;
    localparam int RT_HSW_W  = 7;
    localparam int RT_VSW_W  = 4;
    localparam int RT_NLINE  = 2;

    typedef struct packed {
        logic [RT_CNT_W-1:0] pix;
        logic [RT_CNT_W-1:0] line;
        logic                field;
    } scan_state_t;

    typedef enum logic [1:0] {
        HPOS_ONE_LINE = 2'd0,
        HPOS_OFF_A    = 2'd1,
        HPOS_ALL_LINE = 2'd2,
        HPOS_OFF_B    = 2'd3
    } hpos_mode_e;
endpackage

// File: rtl/rt_scan_counter.sv
module rt_scan_counter
    import raster_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [RT_CNT_W-1:0] h_last_i,
    input  logic [RT_CNT_W-1:0] v_last_i,
    input  logic                interlace_i,
    output scan_state_t         state_o,
    output logic                frame_end_o
);
    scan_state_t state_d, state_q;
    logic        line_end;

    always_comb begin
        state_d     = state_q;
        line_end    = (state_q.pix >= h_last_i);
        frame_end_o = line_end && (state_q.line >= v_last_i);
        if (line_end) begin
            state_d.pix = '0;
            if (frame_end_o) begin
                state_d.line  = '0;
                state_d.field = interlace_i ? ~state_q.field : 1'b0;
            end else begin
                state_d.line = state_q.line + 1'b1;
            end
        end else begin
            state_d.pix = state_q.pix + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign state_o = state_q;
endmodule

// File: rtl/rt_window.sv
module rt_window #(
    parameter int W = 10
) (
    input  logic [W-1:0] pos_i,
    input  logic [W-1:0] start_i,
    input  logic [W-1:0] end_i,
    output logic         outside_o
);
    always_comb begin
        outside_o = !((pos_i >= start_i) && (pos_i < end_i));
    end
endmodule

// File: rtl/rt_irq_gen.sv
module rt_irq_gen
    import raster_pkg::*;
#(
    parameter int NLINE = RT_NLINE
) (
    input  scan_state_t                      state_i,
    input  logic [NLINE-1:0][RT_CNT_W-1:0]   line_pos_i,
    input  logic [RT_CNT_W-1:0]              hpos_pix_i,
    input  logic [RT_CNT_W-1:0]              hpos_line_i,
    input  logic [1:0]                       hpos_mode_i,
    output logic [NLINE-1:0]                 line_irq_o,
    output logic                             hpos_irq_o
);
    logic       at_line_start;
    logic       line_ok;
    hpos_mode_e mode;

    assign at_line_start = (state_i.pix == '0);

    for (genvar g = 0; g < NLINE; g++) begin : g_line_irq
        assign line_irq_o[g] = at_line_start && (state_i.line == line_pos_i[g]);
    end

    always_comb begin
        mode = hpos_mode_e'(hpos_mode_i);
        case (mode)
            HPOS_ONE_LINE: line_ok = (state_i.line == hpos_line_i);
            HPOS_ALL_LINE: line_ok = 1'b1;
            default:       line_ok = 1'b0;
        endcase
        hpos_irq_o = line_ok && (state_i.pix == hpos_pix_i);
    end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import raster_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [RT_CNT_W-1:0] h_last_i,
    input  logic [RT_CNT_W-1:0] v_last_i,
    input  logic [RT_CNT_W-1:0] h_win_start_i,
    input  logic [RT_CNT_W-1:0] h_win_end_i,
    input  logic [RT_CNT_W-1:0] v_win_start_i,
    input  logic [RT_CNT_W-1:0] v_win_end_i,
    input  logic [RT_HSW_W-1:0] hsync_width_i,
    input  logic [RT_VSW_W-1:0] vsync_width_i,
    input  logic                hsync_pol_i,
    input  logic                vsync_pol_i,
    input  logic                interlace_i,
    input  logic                full_border_i,
    input  logic [RT_CNT_W-1:0] irq_line_a_pos_i,
    input  logic [RT_CNT_W-1:0] irq_line_b_pos_i,
    input  logic [RT_CNT_W-1:0] irq_hpos_pix_i,
    input  logic [RT_CNT_W-1:0] irq_hpos_line_i,
    input  logic [1:0]          irq_hpos_mode_i,
    output logic                hsync_o,
    output logic                vsync_o,
    output logic                hblank_o,
    output logic                vblank_o,
    output logic                border_o,
    output logic                field_o,
    output logic [RT_CNT_W-1:0] line_o,
    output logic                irq_line_a_o,
    output logic                irq_line_b_o,
    output logic                irq_hpos_o
);
    scan_state_t                         scan;
    logic                                frame_end;
    logic [RT_NLINE-1:0][RT_CNT_W-1:0]   line_pos;
    logic [RT_NLINE-1:0]                 line_irq;
    logic                                hs_active, vs_active;

    rt_scan_counter i_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .h_last_i    (h_last_i),
        .v_last_i    (v_last_i),
        .interlace_i (interlace_i),
        .state_o     (scan),
        .frame_end_o (frame_end)
    );

    rt_window #(.W(RT_CNT_W)) i_hwin (
        .pos_i     (scan.pix),
        .start_i   (h_win_start_i),
        .end_i     (h_win_end_i),
        .outside_o (hblank_o)
    );

    rt_window #(.W(RT_CNT_W)) i_vwin (
        .pos_i     (scan.line),
        .start_i   (v_win_start_i),
        .end_i     (v_win_end_i),
        .outside_o (vblank_o)
    );

    assign line_pos[0] = irq_line_a_pos_i;
    assign line_pos[1] = irq_line_b_pos_i;

    rt_irq_gen #(.NLINE(RT_NLINE)) i_irq (
        .state_i     (scan),
        .line_pos_i  (line_pos),
        .hpos_pix_i  (irq_hpos_pix_i),
        .hpos_line_i (irq_hpos_line_i),
        .hpos_mode_i (irq_hpos_mode_i),
        .line_irq_o  (line_irq),
        .hpos_irq_o  (irq_hpos_o)
    );

    always_comb begin
        hs_active = (scan.pix  < RT_CNT_W'(hsync_width_i));
        vs_active = (scan.line < RT_CNT_W'(vsync_width_i));
        hsync_o   = hs_active ? hsync_pol_i : ~hsync_pol_i;
        vsync_o   = vs_active ? vsync_pol_i : ~vsync_pol_i;
        border_o  = hblank_o | vblank_o | full_border_i;
    end

    assign irq_line_a_o = line_irq[0];
    assign irq_line_b_o = line_irq[1];
    assign field_o      = scan.field;
    assign line_o       = scan.line;
endmodule

// File: rtl/raster_timing_checker.sv
module raster_timing_checker
    import raster_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [RT_CNT_W-1:0] h_last_i,
    input logic [RT_CNT_W-1:0] v_last_i,
    input logic [RT_CNT_W-1:0] pix,
    input logic [RT_CNT_W-1:0] line_o,
    input logic                field_o,
    input logic                irq_line_a_o,
    input logic                irq_line_b_o,
    input logic                irq_hpos_o
);
    AST_PIX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pix < h_last_i) |=> (pix == $past(pix) + 1'b1)); // R1
    AST_PIX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (pix >= h_last_i) |=> (pix == '0)); // R1
    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pix < h_last_i) |=> $stable(line_o)); // R2
    AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (pix >= h_last_i && line_o >= v_last_i) |=> (line_o == '0)); // R2
    AST_FIELD_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (pix < h_last_i || line_o < v_last_i) |=> $stable(field_o)); // R8
    AST_IRQ_A_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_line_a_o && h_last_i != '0) |=> !irq_line_a_o); // R9
    AST_IRQ_B_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_line_b_o && h_last_i != '0) |=> !irq_line_b_o); // R9
    AST_IRQ_H_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_hpos_o && h_last_i != '0) |=> !irq_hpos_o); // R9
endmodule

bind raster_timing_gen raster_timing_checker i_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .h_last_i     (h_last_i),
    .v_last_i     (v_last_i),
    .pix          (scan.pix),
    .line_o       (line_o),
    .field_o      (field_o),
    .irq_line_a_o (irq_line_a_o),
    .irq_line_b_o (irq_line_b_o),
    .irq_hpos_o   (irq_hpos_o)
);

// File: tb/test_raster_timing_gen.sv
`timescale 1ns/1ps
module test_raster_timing_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] h_last, v_last, hws, hwe, vws, vwe;
    logic [6:0] hsw;
    logic [3:0] vsw;
    logic       hpol, vpol, ilace, fullb;
    logic [9:0] la, lb, hp_pix, hp_line;
    logic [1:0] hp_mode;
    logic       hsync, vsync, hblank, vblank, border, field;
    logic [9:0] line;
    logic       irq_a, irq_b, irq_h;

    int tests = 0;
    int fails = 0;
    int cnt_a, cnt_b, cnt_h;
    bit done = 0;

    always #10 clk = ~clk;

    raster_timing_gen i_raster_timing_gen (
        .clk(clk), .rst_n(rst_n),
        .h_last_i(h_last), .v_last_i(v_last),
        .h_win_start_i(hws), .h_win_end_i(hwe),
        .v_win_start_i(vws), .v_win_end_i(vwe),
        .hsync_width_i(hsw), .vsync_width_i(vsw),
        .hsync_pol_i(hpol), .vsync_pol_i(vpol),
        .interlace_i(ilace), .full_border_i(fullb),
        .irq_line_a_pos_i(la), .irq_line_b_pos_i(lb),
        .irq_hpos_pix_i(hp_pix), .irq_hpos_line_i(hp_line),
        .irq_hpos_mode_i(hp_mode),
        .hsync_o(hsync), .vsync_o(vsync), .hblank_o(hblank), .vblank_o(vblank),
        .border_o(border), .field_o(field), .line_o(line),
        .irq_line_a_o(irq_a), .irq_line_b_o(irq_b), .irq_hpos_o(irq_h)
    );

    task automatic chk(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic defaults();
        h_last = 10'd9;  v_last = 10'd5;
        hws = 10'd2;     hwe = 10'd8;
        vws = 10'd1;     vwe = 10'd4;
        hsw = 7'd3;      vsw = 4'd2;
        hpol = 1'b1;     vpol = 1'b1;
        ilace = 1'b0;    fullb = 1'b0;
        la = 10'd2;      lb = 10'd4;
        hp_pix = 10'd5;  hp_line = 10'd3;
        hp_mode = 2'd0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Compare all outputs against values derived from clock count n since reset
    task automatic run_cycles(int ncyc);
        int hl, vl, fr, h, v, fl, eh, ev, ef, ehs, evs, ebd;
        hl = int'(h_last) + 1;
        vl = int'(v_last) + 1;
        cnt_a = 0; cnt_b = 0; cnt_h = 0;
        for (int n = 0; n < ncyc; n++) begin
            h  = n % hl;
            fl = n / hl;
            v  = fl % vl;
            fr = fl / vl;
            ef = ilace ? (fr % 2) : 0;
            eh = !(h >= int'(hws) && h < int'(hwe));
            ev = !(v >= int'(vws) && v < int'(vwe));
            ehs = (h < int'(hsw)) ? int'(hpol) : int'(!hpol);
            evs = (v < int'(vsw)) ? int'(vpol) : int'(!vpol);
            ebd = (eh || ev || fullb) ? 1 : 0;
            chk("R2 line", int'(line), v);
            chk("R3 hblank", int'(hblank), eh);
            chk("R3 vblank", int'(vblank), ev);
            chk("R4 hsync", int'(hsync), ehs);
            chk("R4 vsync", int'(vsync), evs);
            chk("R5 border", int'(border), ebd);
            chk("R8 field", int'(field), ef);
            chk("R6 irq_a", int'(irq_a), (h == 0 && v == int'(la)) ? 1 : 0);
            chk("R6 irq_b", int'(irq_b), (h == 0 && v == int'(lb)) ? 1 : 0);
            chk("R7 irq_hpos", int'(irq_h),
                (h == int'(hp_pix) && ((hp_mode == 2'd0 && v == int'(hp_line)) ||
                                       hp_mode == 2'd2)) ? 1 : 0);
            cnt_a += int'(irq_a);
            cnt_b += int'(irq_b);
            cnt_h += int'(irq_h);
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        defaults();
        la = 10'd3; lb = 10'd4;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R10 line", int'(line), 0);
        chk("R10 field", int'(field), 0);
        chk("R10 irq_a", int'(irq_a), 0);
        chk("R10 hblank at pixel 0", int'(hblank), 1);
        rst_n = 1'b1;
    endtask

    task automatic t_progressive();
        defaults(); do_reset();
        run_cycles(3 * 60);
        chk("R6 irq_a per 3 frames", cnt_a, 3);
        chk("R6 irq_b per 3 frames", cnt_b, 3);
        chk("R7 mode 0 per 3 frames", cnt_h, 3);
    endtask

    task automatic t_wrap_odd_sizes();
        defaults();
        h_last = 10'd4; v_last = 10'd2;
        hws = 10'd0; hwe = 10'd4; vws = 10'd0; vwe = 10'd2;
        la = 10'd0; lb = 10'd2;
        do_reset();
        run_cycles(2 * 15 + 3);
        chk("R1 R2 wrap irq_a count", cnt_a, 3);
    endtask

    task automatic t_polarity();
        defaults(); hpol = 1'b0; vpol = 1'b0; hsw = 7'd1; vsw = 4'd1;
        do_reset();
        run_cycles(70);
        defaults(); hpol = 1'b1; vpol = 1'b0; hsw = 7'd0;
        do_reset();
        run_cycles(70);
    endtask

    task automatic t_full_border();
        defaults(); fullb = 1'b1;
        do_reset();
        run_cycles(60);
    endtask

    task automatic t_hpos_modes();
        for (int m = 0; m < 4; m++) begin
            defaults(); hp_mode = 2'(m);
            do_reset();
            run_cycles(60);
            chk("R7 pulses per frame", cnt_h, (m == 0) ? 1 : (m == 2) ? 6 : 0);
        end
    endtask

    task automatic t_interlace();
        defaults(); ilace = 1'b1;
        do_reset();
        run_cycles(4 * 60);
        defaults(); ilace = 1'b0;
        do_reset();
        run_cycles(2 * 60);
    endtask

    initial begin
        defaults();
        t_reset();
        t_progressive();
        t_wrap_odd_sizes();
        t_polarity();
        t_full_border();
        t_hpos_modes();
        t_interlace();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule